// File: doc/BRIEF.md
# Probabilistic Cache Admission Filter

This block sits beside a main cache and, on every miss, decides whether the fetched block is allowed into that cache. The decision comes from a comparison between a programmable probability byte and the low byte of an internal pseudo-random generator. A block that is admitted goes to the main cache, where the cache's own replacement policy picks the line it displaces. A block that is refused is recorded in a small fully associative victim buffer instead. The aim is to cut down how often the main cache's contents change.

The victim buffer stores block addresses only. It is filled in first-in first-out order. A separate lookup port lets the surrounding logic ask, within the same cycle, whether an address is held there. The cache controller uses this on a main-cache miss before it goes to memory.

Top module: `vcache_admit_filter`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) empties the victim buffer and loads the generator with 16'hACE1. After reset no probe hits.
- R2: `admit` is 1 exactly when `miss_valid` is 1 and the generator's low 8 bits, read as an unsigned value, are strictly less than `admit_prob`. It is 0 in every cycle without a miss.
- R3: The generator is a 16-bit shift-left Fibonacci LFSR. On each clock edge with `miss_valid` high, the new bit 0 is the XOR of bits 15, 13, 12 and 10, and bits 14..0 move up by one. With no miss it holds its value.
- R4: A miss that is not admitted, and whose address is not already in the victim buffer, puts its address into the buffer. `probe_hit` reports it from the next cycle onward.
- R5: A miss that is admitted leaves the victim buffer unchanged.
- R6: A refused miss whose address is already in the victim buffer is not inserted again and takes no slot. The order in which entries will later be replaced does not change.
- R7: The victim buffer holds 8 addresses. When it is full, a new insertion replaces the oldest inserted entry.
- R8: `probe_hit` is combinational on `probe_addr` and shows the buffer contents as they stood before the current edge. An insertion made in the same cycle is not visible until the next cycle.
- R9: With `admit_prob` = 0 no miss is ever admitted. With `admit_prob` = 255 every miss is admitted except when the generator's low byte is 255.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| miss_valid | input | 1 | Strobe: a main-cache miss is presented this cycle |
| miss_addr | input | 32 | Block address of the miss |
| admit_prob | input | 8 | Admission threshold; probability is admit_prob/256 |
| probe_addr | input | 32 | Address looked up in the victim buffer |
| admit | output | 1 | 1 when the missed block should enter the main cache |
| probe_hit | output | 1 | 1 when probe_addr is held in the victim buffer |

## Verification
The assertions assume that `miss_valid` and `miss_addr` have known values in every cycle after reset, and that reset is held for at least two edges, so that the valid bits are defined before they are compared over time. The stimulus drives every input with a defined value from time zero and holds reset for three cycles. Addresses and probabilities change only just after the falling edge. The address patterns keep repeats inside a small range, so that duplicate refusals and evictions from a full buffer both occur often.

// File: rtl/vcache_admit_filter.sv
module vcache_admit_filter #(
  parameter int ADDR_W = 32,
  parameter int PROB_W = 8,
  parameter int VB_ENTRIES = 8,
  parameter int LFSR_W = 16,
  parameter logic [LFSR_W-1:0] LFSR_SEED = 16'hACE1,
  parameter logic [LFSR_W-1:0] LFSR_TAPS = 16'hB400
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              miss_valid,
  input  logic [ADDR_W-1:0] miss_addr,
  input  logic [PROB_W-1:0] admit_prob,
  input  logic [ADDR_W-1:0] probe_addr,
  output logic              admit,
  output logic              probe_hit
);
  localparam int PTR_W = (VB_ENTRIES > 1) ? $clog2(VB_ENTRIES) : 1;
  localparam logic [PTR_W-1:0] LAST_SLOT = PTR_W'(VB_ENTRIES - 1);

  logic [LFSR_W-1:0]     lfsr_q;
  logic [ADDR_W-1:0]     tag_q [VB_ENTRIES];
  logic [VB_ENTRIES-1:0] vld_q;
  logic [PTR_W-1:0]      wptr_q;
  logic [VB_ENTRIES-1:0] miss_match, probe_match;
  logic                  miss_present, do_insert;

  for (genvar i = 0; i < VB_ENTRIES; i++) begin : g_cmp
    assign miss_match[i]  = vld_q[i] && (tag_q[i] == miss_addr);
    assign probe_match[i] = vld_q[i] && (tag_q[i] == probe_addr);
  end

  assign miss_present = |miss_match;
  assign probe_hit    = |probe_match;
  assign admit        = miss_valid && (lfsr_q[PROB_W-1:0] < admit_prob);
  assign do_insert    = miss_valid && !admit && !miss_present;

  always_ff @(posedge clk) begin
    if (rst) begin
      lfsr_q <= LFSR_SEED;
    end else if (miss_valid) begin
      lfsr_q <= {lfsr_q[LFSR_W-2:0], ^(lfsr_q & LFSR_TAPS)};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q  <= '0;
      wptr_q <= '0;
    end else if (do_insert) begin
      vld_q[wptr_q] <= 1'b1;
      wptr_q        <= (wptr_q == LAST_SLOT) ? '0 : wptr_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (do_insert) tag_q[wptr_q] <= miss_addr;
  end
endmodule

module vcache_admit_filter_chk #(
  parameter int VB_ENTRIES = 8,
  parameter int LFSR_W = 16,
  parameter int PTR_W = 3
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  miss_valid,
  input logic                  admit,
  input logic                  miss_present,
  input logic [LFSR_W-1:0]     lfsr_q,
  input logic [VB_ENTRIES-1:0] vld_q,
  input logic [PTR_W-1:0]      wptr_q
);
  // R1
  lfsr_nonzero_chk: assert property (@(posedge clk) disable iff (rst) lfsr_q != '0);
  // R2
  admit_needs_miss_chk: assert property (@(posedge clk) disable iff (rst) admit |-> miss_valid);
  // R3
  lfsr_hold_chk: assert property (@(posedge clk) disable iff (rst) !miss_valid |=> $stable(lfsr_q));
  // R5
  admitted_no_insert_chk: assert property (@(posedge clk) disable iff (rst)
    (miss_valid && admit) |=> ($stable(vld_q) && $stable(wptr_q)));
  // R6
  dup_no_insert_chk: assert property (@(posedge clk) disable iff (rst)
    (miss_valid && miss_present) |=> ($stable(vld_q) && $stable(wptr_q)));
  // R7
  valid_monotonic_chk: assert property (@(posedge clk) disable iff (rst)
    $countones(vld_q) >= $countones($past(vld_q)));
  // R4
  refused_insert_chk: assert property (@(posedge clk) disable iff (rst)
    (miss_valid && !admit && !miss_present) |=> !$stable(wptr_q));
endmodule

bind vcache_admit_filter vcache_admit_filter_chk #(
  .VB_ENTRIES(VB_ENTRIES), .LFSR_W(LFSR_W), .PTR_W(PTR_W)
) u_chk (
  .clk(clk), .rst(rst), .miss_valid(miss_valid), .admit(admit),
  .miss_present(miss_present), .lfsr_q(lfsr_q), .vld_q(vld_q), .wptr_q(wptr_q)
);

// File: tb/vcache_admit_filter_tb.sv
module vcache_admit_filter_tb;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 8;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        miss_valid = 1'b0;
  logic [31:0] miss_addr = '0;
  logic [7:0]  admit_prob = '0;
  logic [31:0] probe_addr = '0;
  logic        admit, probe_hit;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  int unsigned m_lfsr;
  int unsigned m_q[$];

  vcache_admit_filter u_dut (
    .clk(clk), .rst(rst), .miss_valid(miss_valid), .miss_addr(miss_addr),
    .admit_prob(admit_prob), .probe_addr(probe_addr),
    .admit(admit), .probe_hit(probe_hit)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic bit m_has(int unsigned a);
    foreach (m_q[i]) if (m_q[i] == a) return 1'b1;
    return 1'b0;
  endfunction

  task automatic check(string req, int unsigned act, int unsigned exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // drives one cycle, compares, then advances the model across the edge
  task automatic step(bit mv, int unsigned ma, int unsigned pa, string req);
    bit e_admit;
    miss_valid = mv; miss_addr = ma; probe_addr = pa;
    #1;
    e_admit = mv && ((m_lfsr & 8'hFF) < admit_prob);
    check({req, " admit (R2)"}, admit, e_admit);
    check({req, " probe"}, probe_hit, m_has(pa));
    if (mv && !e_admit && !m_has(ma)) begin
      if (m_q.size() == DEPTH) void'(m_q.pop_front());
      m_q.push_back(ma);
    end
    if (mv) m_lfsr = ((m_lfsr << 1) & 16'hFFFF) |
                     (((m_lfsr >> 15) ^ (m_lfsr >> 13) ^ (m_lfsr >> 12) ^ (m_lfsr >> 10)) & 1);
    @(negedge clk);
  endtask

  initial begin
    m_lfsr = 16'hACE1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: empty after reset, no admit without miss
    for (int i = 0; i < 4; i++) step(1'b0, 0, 32'h100 + i, "R1");
    // R9 with p=0, R4 fill, R8 same-cycle probe of inserted address
    admit_prob = 8'd0;
    for (int i = 0; i < 6; i++) step(1'b1, 32'h200 + i, 32'h200 + i, "R8");
    // R6 duplicates of present entries
    for (int i = 0; i < 6; i++) step(1'b1, 32'h200 + (i % 3), 32'h200 + i, "R6");
    // R7 overflow: oldest entries leave in order
    for (int i = 0; i < 12; i++) step(1'b1, 32'h300 + i, 32'h200 + (i % 8), "R7");
    for (int i = 0; i < 12; i++) step(1'b0, 0, 32'h300 + i, "R7");
    // R5 / R9 with p=255
    admit_prob = 8'd255;
    for (int i = 0; i < 40; i++) step(1'b1, 32'h400 + i, 32'h400 + i, "R5");
    for (int i = 0; i < 12; i++) step(1'b0, 0, 32'h400 + i, "R5");
    // R3 mixed idle and miss cycles, mid probability
    admit_prob = 8'd128;
    for (int i = 0; i < 3000; i++) begin
      if (i % 500 == 0) admit_prob = 8'($urandom_range(1, 254));
      step(1'($urandom_range(0, 2) != 0), $urandom_range(0, 20),
           $urandom_range(0, 20), "R3");
    end
    // R1 reset mid-run clears buffer and reseeds
    rst = 1'b1;
    @(negedge clk); @(negedge clk);
    rst = 1'b0;
    m_q.delete();
    m_lfsr = 16'hACE1;
    admit_prob = 8'd200;
    for (int i = 0; i < 30; i++) step(1'b1, i % 10, i % 12, "R1");
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule